// File: doc/BRIEF.md
# Configuration Pin Refresh Handshake

This controller places an attached programmable-logic device into its programming state before a bitstream is loaded, and supervises the end of configuration afterwards. When the board has all three configuration pins wired (an active-low program output, an active-low init input and an active-high done input), it runs a pin handshake. When any of them is missing, it asks an external SPI command engine to send a four-byte refresh command and then waits a fixed settling time.

Every pin wait samples the synchronised pin at a fixed poll interval and gives up after a fixed timeout. A failed wait leaves a small error code and returns the program pin to its inactive level. The finish request sends a four-byte disable command. When the done pin is wired, the block then waits for done to rise under the same timeout. All timers are cycle counts derived from a clock-frequency parameter. Moving the bitstream itself is handled elsewhere.

Top module: `cfg_refresh_ctrl`

## Requirements
- R1: After reset, prog_no is 1, busy_o, rdy_o and cmd_req_o are 0, and err_o is 0.
- R2: A start request runs the pin handshake only when pin_conn_i is 3'b111 (bit 0 program, bit 1 init, bit 2 done). Otherwise prog_no stays 1 and the command word 32'h7900_0000 is issued, with the first byte sent in bits 31:24.
- R3: The pin handshake drives prog_no to 0 and waits for init low, then for done low. It then sets prog_no back to 1 and waits for init high, and only then sets rdy_o.
- R4: Each pin wait samples the synchronised pin once every POLL_US microseconds. A wait fails on its PIN_TIMEOUT_US/POLL_US-th sample without success, POLL_US*PIN_TIMEOUT_US/POLL_US microseconds after the wait began.
- R5: A failed wait sets err_o to a code and leaves rdy_o at 0 and prog_no at 1. The codes are 1 for init never going low, 2 for done never going low, 3 for init never going high again and 4 for done never going high.
- R6: After the refresh command is acknowledged, rdy_o rises no sooner than SETTLE_US microseconds later.
- R7: A finish request issues the command word 32'h2600_0000. If pin_conn_i bit 2 is set, the block then waits for done high under the R4 timing. Otherwise it sets rdy_o once the command is acknowledged.
- R8: cmd_req_o stays high with cmd_word_o unchanged until cmd_ack_i is seen, and each operation issues exactly one command.
- R9: start_i and finish_i are ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to enter programming mode |
| finish_i | input | 1 | Request to end configuration |
| pin_conn_i | input | 3 | Wired-pin strap: bit 0 program, bit 1 init, bit 2 done |
| prog_no | output | 1 | Program pin, active low |
| init_ni | input | 1 | Raw init pin, active low, asynchronous |
| done_i | input | 1 | Raw done pin, active high, asynchronous |
| cmd_req_o | output | 1 | Command request to SPI engine |
| cmd_word_o | output | 32 | Four-byte command, first byte in bits 31:24 |
| cmd_ack_i | input | 1 | One-cycle command completion from SPI engine |
| busy_o | output | 1 | An operation is in progress |
| rdy_o | output | 1 | Last operation succeeded |
| err_o | output | 3 | Error code of last operation, 0 when none |

## Verification
The assertions check on every cycle the properties that hold at all times. The program pin is inactive whenever the block is idle and during any refresh command. An error never coexists with ready and always comes with the program pin released. A command request holds its word until it is acknowledged. Busy rises only on a request. The settling window after a refresh is counted in the checker. The choice between pin and command modes for each strap, the order of the handshake steps, the exact timeout length and the error code of each failing step depend on a modelled target device, so only the bench scenarios can show them.

// File: rtl/cfg_refresh_pkg.sv
package cfg_refresh_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_INIT_ACT,
    ST_W_DONE_CLR,
    ST_W_INIT_REL,
    ST_REFRESH,
    ST_SETTLE,
    ST_DISABLE,
    ST_W_DONE_SET
  } cfg_st_e;

  localparam logic [31:0] CMD_REFRESH = 32'h7900_0000;
  localparam logic [31:0] CMD_DISABLE = 32'h2600_0000;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_INIT_ACT = 3'd1;
  localparam logic [2:0] ERR_DONE_CLR = 3'd2;
  localparam logic [2:0] ERR_INIT_REL = 3'd3;
  localparam logic [2:0] ERR_DONE_SET = 3'd4;

  localparam int PIN_PROG = 0;
  localparam int PIN_INIT = 1;
  localparam int PIN_DONE = 2;
  localparam int NUM_PINS = 3;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
  parameter int unsigned POLL_CYC  = 3000,
  parameter int unsigned MAX_POLLS = 3333
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o,
  output logic last_o
);
  localparam int CW = (POLL_CYC  > 1) ? $clog2(POLL_CYC)  : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] polls_q;

  assign tick_o = (cnt_q == CW'(POLL_CYC - 1));
  assign last_o = (polls_q == PW'(MAX_POLLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      polls_q <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      polls_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      if (!last_o) polls_q <= polls_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_refresh_ctrl.sv
module cfg_refresh_ctrl
  import cfg_refresh_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 100_000_000,
  parameter int unsigned POLL_US        = 30,
  parameter int unsigned PIN_TIMEOUT_US = 100_000,
  parameter int unsigned SETTLE_US      = 4_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        finish_i,
  input  logic [2:0]  pin_conn_i,
  output logic        prog_no,
  input  logic        init_ni,
  input  logic        done_i,
  output logic        cmd_req_o,
  output logic [31:0] cmd_word_o,
  input  logic        cmd_ack_i,
  output logic        busy_o,
  output logic        rdy_o,
  output logic [2:0]  err_o
);
  localparam int unsigned CYC_PER_US = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned POLL_CYC   = (CYC_PER_US * POLL_US > 0) ? CYC_PER_US * POLL_US : 1;
  localparam int unsigned MAX_POLLS  = (POLL_US > 0 && PIN_TIMEOUT_US / POLL_US > 0) ?
                                       PIN_TIMEOUT_US / POLL_US : 1;
  localparam int unsigned SETTLE_CYC = (CYC_PER_US * SETTLE_US > 0) ? CYC_PER_US * SETTLE_US : 1;
  localparam int          SW         = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  // init reset to inactive (1), done reset to 0
  logic [1:0] pins_s;
  logic       init_n_s, done_s;

  cfg_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, init_ni}),
    .q_o   (pins_s)
  );
  assign init_n_s = pins_s[0];
  assign done_s   = pins_s[1];

  cfg_st_e     st_q, st_d;
  logic        prog_q, prog_d;
  logic        req_q, req_d;
  logic [31:0] word_q, word_d;
  logic        rdy_q, rdy_d;
  logic [2:0]  err_q, err_d;
  logic        tick, last_poll;
  logic [SW-1:0] settle_q;
  logic        settle_last;

  wire all_wired  = &pin_conn_i;
  wire done_wired = pin_conn_i[PIN_DONE];

  cfg_poll_timer #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_d != st_q),
    .tick_o(tick),
    .last_o(last_poll)
  );

  assign settle_last = (settle_q == SW'(SETTLE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                settle_q <= '0;
    else if (st_q != ST_SETTLE) settle_q <= '0;
    else if (!settle_last)      settle_q <= settle_q + 1'b1;
  end

  always_comb begin
    st_d   = st_q;
    prog_d = prog_q;
    req_d  = req_q;
    word_d = word_q;
    rdy_d  = rdy_q;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          rdy_d = 1'b0;
          err_d = ERR_NONE;
          if (all_wired) begin
            prog_d = 1'b0;
            st_d   = ST_W_INIT_ACT;
          end else begin
            req_d  = 1'b1;
            word_d = CMD_REFRESH;
            st_d   = ST_REFRESH;
          end
        end else if (finish_i) begin
          rdy_d  = 1'b0;
          err_d  = ERR_NONE;
          req_d  = 1'b1;
          word_d = CMD_DISABLE;
          st_d   = ST_DISABLE;
        end
      end
      ST_W_INIT_ACT: if (tick) begin
        if (!init_n_s) st_d = ST_W_DONE_CLR;
        else if (last_poll) begin
          err_d = ERR_INIT_ACT; prog_d = 1'b1; st_d = ST_IDLE;
        end
      end
      ST_W_DONE_CLR: if (tick) begin
        if (!done_s) begin
          prog_d = 1'b1; st_d = ST_W_INIT_REL;
        end else if (last_poll) begin
          err_d = ERR_DONE_CLR; prog_d = 1'b1; st_d = ST_IDLE;
        end
      end
      ST_W_INIT_REL: if (tick) begin
        if (init_n_s) begin
          rdy_d = 1'b1; st_d = ST_IDLE;
        end else if (last_poll) begin
          err_d = ERR_INIT_REL; st_d = ST_IDLE;
        end
      end
      ST_REFRESH: if (cmd_ack_i) begin
        req_d = 1'b0; st_d = ST_SETTLE;
      end
      ST_SETTLE: if (settle_last) begin
        rdy_d = 1'b1; st_d = ST_IDLE;
      end
      ST_DISABLE: if (cmd_ack_i) begin
        req_d = 1'b0;
        if (done_wired) st_d = ST_W_DONE_SET;
        else begin
          rdy_d = 1'b1; st_d = ST_IDLE;
        end
      end
      ST_W_DONE_SET: if (tick) begin
        if (done_s) begin
          rdy_d = 1'b1; st_d = ST_IDLE;
        end else if (last_poll) begin
          err_d = ERR_DONE_SET; st_d = ST_IDLE;
        end
      end
      default: begin
        prog_d = 1'b1; req_d = 1'b0; st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prog_q <= 1'b1;
      req_q  <= 1'b0;
      word_q <= '0;
      rdy_q  <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      st_q   <= st_d;
      prog_q <= prog_d;
      req_q  <= req_d;
      word_q <= word_d;
      rdy_q  <= rdy_d;
      err_q  <= err_d;
    end
  end

  assign prog_no    = prog_q;
  assign cmd_req_o  = req_q;
  assign cmd_word_o = word_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign rdy_o      = rdy_q;
  assign err_o      = err_q;
endmodule

// File: rtl/cfg_refresh_chk.sv
module cfg_refresh_chk
  import cfg_refresh_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 400_000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        finish_i,
  input logic        prog_no,
  input logic        cmd_req_o,
  input logic [31:0] cmd_word_o,
  input logic        cmd_ack_i,
  input logic        busy_o,
  input logic        rdy_o,
  input logic [2:0]  err_o
);
  localparam int CW = $clog2(SETTLE_CYC + 2);

  logic [CW-1:0] since_ack_q;
  logic          last_refresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_ack_q    <= '0;
      last_refresh_q <= 1'b0;
    end else if (cmd_ack_i && cmd_req_o) begin
      since_ack_q    <= '0;
      last_refresh_q <= (cmd_word_o == CMD_REFRESH);
    end else if (since_ack_q != CW'(SETTLE_CYC)) begin
      since_ack_q <= since_ack_q + 1'b1;
    end
  end

  a_r3_prog_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> prog_no);

  a_r2_refresh_no_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && cmd_word_o == CMD_REFRESH) |-> prog_no);

  a_r5_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != ERR_NONE) |-> (!rdy_o && prog_no));

  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_word_o)));

  a_r6_settle_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rdy_o) && last_refresh_q) |-> (since_ack_q >= CW'(SETTLE_CYC)));

  a_r9_busy_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i || finish_i));
endmodule

bind cfg_refresh_ctrl cfg_refresh_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .finish_i  (finish_i),
  .prog_no   (prog_no),
  .cmd_req_o (cmd_req_o),
  .cmd_word_o(cmd_word_o),
  .cmd_ack_i (cmd_ack_i),
  .busy_o    (busy_o),
  .rdy_o     (rdy_o),
  .err_o     (err_o)
);

// File: tb/cfg_refresh_ctrl_test.sv
module cfg_refresh_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int POLL       = 3;
  localparam int NPOLL      = 10;
  localparam int SETTLE     = 20;

  typedef struct packed {
    logic [2:0] pins;
    logic [1:0] beh;    // 0 good, 1 init stuck high, 2 done stuck high, 3 init stuck low
    logic [2:0] err;
    logic       rdy;
    logic       prog;
    logic       refr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'b111, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0},
    '{3'b011, 2'd0, 3'd0, 1'b1, 1'b0, 1'b1},
    '{3'b101, 2'd0, 3'd0, 1'b1, 1'b0, 1'b1},
    '{3'b000, 2'd0, 3'd0, 1'b1, 1'b0, 1'b1},
    '{3'b111, 2'd1, 3'd1, 1'b0, 1'b1, 1'b0},
    '{3'b111, 2'd2, 3'd2, 1'b0, 1'b1, 1'b0},
    '{3'b111, 2'd3, 3'd3, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, finish_i = 1'b0;
  logic [2:0] pin_conn_i = 3'b111;
  logic init_ni = 1'b1, done_i = 1'b1, cmd_ack_i = 1'b0;
  logic prog_no, cmd_req_o, busy_o, rdy_o;
  logic [31:0] cmd_word_o;
  logic [2:0] err_o;

  int checks = 0, failures = 0;
  logic [1:0] beh = 2'd0;
  logic done_drv = 1'b1;
  logic prog_seen = 1'b0, prog_went_low = 1'b0;
  int cmd_cnt = 0, refresh_cnt = 0, disable_cnt = 0;
  int since_ack = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_refresh_ctrl #(
    .CLK_HZ(1_000_000), .POLL_US(POLL), .PIN_TIMEOUT_US(POLL*NPOLL), .SETTLE_US(SETTLE)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .finish_i(finish_i),
    .pin_conn_i(pin_conn_i), .prog_no(prog_no), .init_ni(init_ni), .done_i(done_i),
    .cmd_req_o(cmd_req_o), .cmd_word_o(cmd_word_o), .cmd_ack_i(cmd_ack_i),
    .busy_o(busy_o), .rdy_o(rdy_o), .err_o(err_o)
  );

  // target device and SPI engine models, updated away from the active edge
  always @(negedge clk) begin
    if (!prog_no) begin
      prog_seen     = 1'b1;
      prog_went_low = 1'b1;
      init_ni       = (beh == 2'd1);
      done_i        = (beh == 2'd2);
    end else begin
      init_ni = !(beh == 2'd3 && prog_went_low);
      done_i  = prog_went_low ? (beh == 2'd2) || done_drv : done_drv;
    end
    since_ack++;
    if (cmd_req_o && !cmd_ack_i) begin
      cmd_ack_i = 1'b1;
      cmd_cnt++;
      since_ack = 0;
      if (cmd_word_o == 32'h7900_0000) refresh_cnt++;
      if (cmd_word_o == 32'h2600_0000) disable_cnt++;
    end else begin
      cmd_ack_i = 1'b0;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model(input logic [1:0] b, input logic dn);
    beh = b; done_drv = dn; prog_seen = 1'b0; prog_went_low = 1'b0;
    cmd_cnt = 0; refresh_cnt = 0; disable_cnt = 0;
  endtask

  // pulse a request, return negedges until idle
  task automatic run_op(input logic is_start, output int n);
    if (is_start) start_i = 1'b1; else finish_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; finish_i = 1'b0;
    n = 1;
    while (busy_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(prog_no === 1'b1, "R1 prog", prog_no, 1);
    check(busy_o === 1'b0 && rdy_o === 1'b0 && cmd_req_o === 1'b0, "R1 status",
          {busy_o, rdy_o, cmd_req_o}, 0);
    check(err_o === 3'd0, "R1 err", err_o, 0);
    do_reset();

    // vector table: R2 R3 R5 R8
    for (int i = 0; i < 7; i++) begin
      pin_conn_i = VECS[i].pins;
      clear_model(VECS[i].beh, 1'b1);
      @(negedge clk);
      run_op(1'b1, n);
      check(err_o == VECS[i].err, $sformatf("R5 err row %0d", i), err_o, VECS[i].err);
      check(rdy_o == VECS[i].rdy, $sformatf("R3 rdy row %0d", i), rdy_o, VECS[i].rdy);
      check(prog_seen == VECS[i].prog, $sformatf("R2 prog used row %0d", i),
            prog_seen, VECS[i].prog);
      check(refresh_cnt == int'(VECS[i].refr), $sformatf("R8 refresh count row %0d", i),
            refresh_cnt, VECS[i].refr);
      check(prog_no === 1'b1, $sformatf("R5 prog released row %0d", i), prog_no, 1);
      if (i == 4)
        check(n >= POLL*NPOLL && n <= POLL*NPOLL + 3, "R4 init timeout length", n,
              POLL*NPOLL + 1);
    end

    // R6 settle after refresh ack
    pin_conn_i = 3'b011;
    clear_model(2'd0, 1'b1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!rdy_o && since_ack < 500) @(negedge clk);
    check(since_ack >= SETTLE && since_ack <= SETTLE + 2, "R6 settle time", since_ack, SETTLE + 1);

    // R9 requests ignored while busy
    clear_model(2'd0, 1'b1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    finish_i = 1'b1;
    @(negedge clk);
    finish_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    check(cmd_cnt == 1 && disable_cnt == 0, "R9 one command", cmd_cnt, 1);
    check(busy_o === 1'b0 && rdy_o === 1'b1, "R9 result kept", rdy_o, 1);

    // R7 finish, done wired and rising
    pin_conn_i = 3'b111;
    clear_model(2'd0, 1'b1);
    run_op(1'b0, n);
    check(disable_cnt == 1 && cmd_cnt == 1, "R7 disable sent", disable_cnt, 1);
    check(rdy_o === 1'b1 && err_o == 3'd0, "R7 done seen", err_o, 0);

    // R7 finish, done wired but stays low -> code 4
    clear_model(2'd0, 1'b0);
    run_op(1'b0, n);
    check(err_o == 3'd4 && rdy_o === 1'b0, "R7 done timeout code", err_o, 4);
    check(n >= POLL*NPOLL && n <= POLL*NPOLL + 4, "R4 done timeout length", n, POLL*NPOLL + 2);

    // R7 finish, done not wired: ready on ack, done level irrelevant
    pin_conn_i = 3'b011;
    clear_model(2'd0, 1'b0);
    run_op(1'b0, n);
    check(rdy_o === 1'b1 && err_o == 3'd0, "R7 unwired done ready", rdy_o, 1);
    check(n <= 4, "R7 unwired done fast", n, 2);

    // R2 refresh word value observed on the port
    clear_model(2'd0, 1'b1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(cmd_req_o === 1'b1 && cmd_word_o == 32'h7900_0000, "R2 refresh word",
          cmd_word_o, 32'h7900_0000);
    while (busy_o) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule